// File: doc/BRIEF.md
# Receive Buffer Status Tracker

This block keeps the receive-side status of a CAN controller's message buffers. An upstream receiver that has already done acceptance filtering reports each stored message as a one-cycle event. The event carries the buffer index and whether the frame was a remote frame or a data frame. For every buffer the block keeps five bits: an enable bit, a receive-complete bit, a remote-request bit, an overrun bit and an interrupt-enable bit. One global halt bit blocks all reception while the controller is being configured.

Software reaches the bit vectors through a small register bus. A write strobe, a 3-bit address and an N-bit write word go in, and an N-bit read word comes out combinationally. The status flags are cleared by writing zero to them. Software clears a buffer's complete bit once it has processed that buffer, and this also withdraws the buffer's interrupt request. A single registered interrupt line reports whether any buffer has a complete bit set together with its interrupt-enable bit.

Top module: `rx_buf_status`

## Requirements
- R1: A store event changes a buffer's state only when that buffer's enable bit (address 1, bit x) is 1.
- R2: The halt bit (address 0, bit 0) is 1 after reset. It is plain read/write. While it is 1, store events are ignored.
- R3: An accepted store to buffer x sets complete bit x (address 2) in the next cycle.
- R4: An accepted store to buffer x sets remote-request bit x (address 3) to 1 for a remote frame (st_remote=1) and to 0 for a data frame.
- R5: The irq output is registered. It is high one cycle after any buffer has both its complete bit and its interrupt-enable bit (address 5) at 1.
- R6: Writing 0 to complete bit x clears that bit, and the interrupt it caused drops on the following cycle.
- R7: An accepted store to buffer x while complete bit x is already 1 sets overrun bit x (address 4).
- R8: The complete, remote-request and overrun bits are write-0-to-clear: a written 1 leaves the bit unchanged. When a hardware update and a software clear hit the same bit in one cycle, the hardware value wins.
- R9: The enable and interrupt-enable vectors are plain read/write. Addresses 6 and 7 read as 0 and ignore writes.
- R10: After reset, every per-buffer bit and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Message-stored event |
| st_idx | input | IW | Buffer index of the event |
| st_remote | input | 1 | 1 = remote frame, 0 = data frame |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address |
| wdata | input | NBUF | Write data |
| rdata | output | NBUF | Read data for addr |
| irq | output | 1 | Receive interrupt |

## Verification
The bench targets the cycles where a hardware store and a software clear land on the same buffer. A design that let the clear win there would lose a completion or an overrun. It repeats stores to buffers that are still complete: a design that missed that case would never raise overrun, and one that set overrun on every store would flag false overruns. It stores to disabled buffers and stores while halted, where a design that leaked the event would set complete bits that software never armed. It also writes all-ones to the clear-only registers, which would wrongly set flags in a design that treated those registers as plain storage.

// File: rtl/rx_buf_status.sv
module rx_buf_status #(
  parameter int NBUF = 16,
  parameter int AW   = 3,
  parameter int IW   = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_valid,
  input  logic [IW-1:0]   st_idx,
  input  logic            st_remote,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [NBUF-1:0] wdata,
  output logic [NBUF-1:0] rdata,
  output logic            irq
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_EN   = AW'(1);
  localparam logic [AW-1:0] A_CMP  = AW'(2);
  localparam logic [AW-1:0] A_RRQ  = AW'(3);
  localparam logic [AW-1:0] A_OVR  = AW'(4);
  localparam logic [AW-1:0] A_IE   = AW'(5);
  localparam logic [NBUF-1:0] ONE  = {{(NBUF-1){1'b0}}, 1'b1};

  logic            halt_q, irq_q;
  logic [NBUF-1:0] en_q, cmp_q, rrq_q, ovr_q, ie_q;

  wire             hit = st_valid && !halt_q && (32'(st_idx) < NBUF) && en_q[st_idx];
  wire [NBUF-1:0]  sel = hit ? (ONE << st_idx) : '0;

  wire wr_ctrl = wr_en && addr == A_CTRL;
  wire wr_en_v = wr_en && addr == A_EN;
  wire wr_cmp  = wr_en && addr == A_CMP;
  wire wr_rrq  = wr_en && addr == A_RRQ;
  wire wr_ovr  = wr_en && addr == A_OVR;
  wire wr_ie   = wr_en && addr == A_IE;

  wire [NBUF-1:0] cmp_sw = wr_cmp ? (cmp_q & wdata) : cmp_q;
  wire [NBUF-1:0] rrq_sw = wr_rrq ? (rrq_q & wdata) : rrq_q;
  wire [NBUF-1:0] ovr_sw = wr_ovr ? (ovr_q & wdata) : ovr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q <= 1'b1;
      en_q   <= '0;
      cmp_q  <= '0;
      rrq_q  <= '0;
      ovr_q  <= '0;
      ie_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ctrl) halt_q <= wdata[0];
      if (wr_en_v) en_q   <= wdata;
      if (wr_ie)   ie_q   <= wdata;
      cmp_q <= cmp_sw | sel;
      ovr_q <= ovr_sw | (sel & cmp_q);
      rrq_q <= (rrq_sw & ~sel) | (sel & {NBUF{st_remote}});
      irq_q <= |(cmp_q & ie_q);
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {{(NBUF-1){1'b0}}, halt_q};
      A_EN:    rdata = en_q;
      A_CMP:   rdata = cmp_q;
      A_RRQ:   rdata = rrq_q;
      A_OVR:   rdata = ovr_q;
      A_IE:    rdata = ie_q;
      default: rdata = '0;
    endcase
  end

  assign irq = irq_q;

  assert_halt_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !wr_en) |=> $stable(cmp_q));
  assert_store_sets_complete_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cmp_q[$past(st_idx)]);
  assert_frame_type_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> rrq_q[$past(st_idx)] == $past(st_remote));
  assert_irq_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(cmp_q & ie_q)) |=> !irq);
  assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cmp_q[st_idx]) |=> ovr_q[$past(st_idx)]);
  assert_no_set_by_sw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ((cmp_q & ~$past(cmp_q)) == '0 && (ovr_q & ~$past(ovr_q)) == '0));
  assert_disabled_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !en_q[st_idx] && !wr_en) |=> $stable(cmp_q) && $stable(ovr_q));
endmodule

// File: tb/rx_buf_status_test.sv
module rx_buf_status_test;
  localparam int N  = 16;
  localparam int IW = 4;

  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n = 0, st_valid = 0, st_remote = 0, wr_en = 0;
  logic [IW-1:0] st_idx = '0;
  logic [2:0] addr = '0;
  logic [N-1:0] wdata = '0, rdata;
  logic irq;

  rx_buf_status #(.NBUF(N)) uut (.clk, .rst_n, .st_valid, .st_idx, .st_remote,
    .wr_en, .addr, .wdata, .rdata, .irq);

  int total = 0, bad = 0;
  string phase = "R10 reset";
  bit started = 0;
  bit m_halt, m_irq;
  bit [N-1:0] m_en, m_cmp, m_rrq, m_ovr, m_ie;

  always @(posedge clk) begin
    bit nirq, acc, was;
    started = 1;
    if (!rst_n) begin
      m_halt = 1; m_irq = 0;
      m_en = 0; m_cmp = 0; m_rrq = 0; m_ovr = 0; m_ie = 0;
    end else begin
      nirq = 0;
      for (int i = 0; i < N; i++) if (m_cmp[i] && m_ie[i]) nirq = 1;
      acc = st_valid && !m_halt && m_en[st_idx];
      was = m_cmp[st_idx];
      if (wr_en) begin
        for (int i = 0; i < N; i++) begin
          if (addr == 2 && !wdata[i]) m_cmp[i] = 0;
          if (addr == 3 && !wdata[i]) m_rrq[i] = 0;
          if (addr == 4 && !wdata[i]) m_ovr[i] = 0;
        end
        if (addr == 0) m_halt = wdata[0];
        if (addr == 1) m_en = wdata;
        if (addr == 5) m_ie = wdata;
      end
      if (acc) begin
        m_cmp[st_idx] = 1;
        if (was) m_ovr[st_idx] = 1;
        m_rrq[st_idx] = st_remote;
      end
      m_irq = nirq;
    end
  end

  function automatic bit [N-1:0] exp_rd(input logic [2:0] a);
    case (a)
      0: return {{(N-1){1'b0}}, m_halt};
      1: return m_en;
      2: return m_cmp;
      3: return m_rrq;
      4: return m_ovr;
      5: return m_ie;
      default: return '0;
    endcase
  endfunction

  always @(negedge clk) if (started) begin
    total++;
    if (rdata !== exp_rd(addr)) begin
      bad++;
      $display("FAIL %s addr=%0d rdata=%h expected=%h", phase, addr, rdata, exp_rd(addr));
    end
    total++;
    if (irq !== m_irq) begin
      bad++;
      $display("FAIL %s irq=%0b expected=%0b", phase, irq, m_irq);
    end
  end

  task automatic tick(bit sv, int idx, bit rem, bit w, int a, bit [N-1:0] d);
    st_valid = sv; st_idx = IW'(idx); st_remote = rem;
    wr_en = w; addr = 3'(a); wdata = d;
    @(posedge clk); #1;
    st_valid = 0; wr_en = 0;
  endtask

  task automatic rd(int a);
    tick(0, 0, 0, 0, a, '0);
  endtask

  task automatic rd_all();
    for (int a = 0; a < 8; a++) rd(a);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    phase = "R10 reset values"; rd_all();
    phase = "R2 store while halted";
    tick(0, 0, 0, 1, 1, 16'hFFFF);
    tick(1, 3, 0, 0, 2, '0); rd(2); rd(0);
    tick(0, 0, 0, 1, 0, 16'h0000); rd(0);
    phase = "R1 disabled buffer";
    tick(0, 0, 0, 1, 1, 16'h00FF);
    tick(1, 9, 1, 0, 2, '0); rd(2); rd(3);
    phase = "R3 R4 data and remote stores";
    tick(1, 1, 0, 0, 2, '0);
    tick(1, 2, 1, 0, 3, '0); rd_all();
    phase = "R5 irq";
    tick(0, 0, 0, 1, 5, 16'h0002); rd(5); rd(2); rd(2);
    phase = "R7 overrun";
    tick(1, 1, 1, 0, 4, '0); rd(4); rd(3);
    phase = "R6 clear complete";
    tick(0, 0, 0, 1, 2, 16'hFFFD); rd(2); rd(2); rd(2);
    phase = "R8 write ones ignored";
    tick(0, 0, 0, 1, 2, 16'hFFFF); rd(2);
    tick(0, 0, 0, 1, 4, 16'hFFFF); rd(4);
    tick(0, 0, 0, 1, 3, 16'hFFFF); rd(3);
    phase = "R8 set wins over clear";
    tick(1, 3, 1, 1, 2, 16'h0000); rd(2);
    tick(1, 3, 0, 1, 4, 16'h0000); rd(4);
    tick(1, 4, 1, 1, 3, 16'h0000); rd(3);
    phase = "R9 plain registers";
    tick(0, 0, 0, 1, 1, 16'hA5C3); rd(1);
    tick(0, 0, 0, 1, 5, 16'h5A3C); rd(5);
    tick(0, 0, 0, 1, 6, 16'hFFFF); rd(6); rd(7);
    phase = "R1-R9 mixed traffic";
    for (int k = 0; k < 3000; k++) begin
      bit sv, w; int a;
      sv = ($urandom % 3) != 0;
      w  = ($urandom % 4) == 0;
      a  = $urandom % 8;
      if (w && a == 0 && ($urandom % 4) != 0) a = 2;
      tick(sv, $urandom % N, $urandom % 2, w, a,
           (a == 0) ? N'($urandom % 5 == 0) : N'($urandom));
    end
    phase = "R10 reset again";
    rst_n = 0; rd(2); rd(0);
    rst_n = 1; rd_all();
    @(negedge clk); #1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule